// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock for an I2C master. It holds four programmable
count registers: a high count and a low count for standard speed, and the same pair
for fast speed. A speed-select input chooses which pair times each phase. Every
high phase lasts the selected high count plus a fixed three-cycle overhead. Every
low phase lasts the selected low count plus one cycle. Low-phase timing starts in
the same cycle that the block begins driving SCL low.

The output is a drive-low request for the SCL pad, which is released (high) while
the generator is off. Two single-cycle strobes, one for each SCL edge, tell the bit
engine where the phase boundaries are. The count registers are written through a
small write port. That port only takes effect while the generator is disabled, so
the period cannot change partway through a transfer. The block carries no data
stream, so every pin is a plain control or status signal and nothing applies
back-pressure.

Top module: `scl_period_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_drive_low`, `scl_fall_stb` and `scl_rise_stb` are 0. After reset the count registers hold the parameter defaults: standard high 10, standard low 12, fast high 2, fast low 4.
- R2: From the clock edge that samples `enable` at 0, `scl_drive_low` and both strobes are 0 and stay 0 while `enable` remains 0.
- R3: A `speed_sel` value of 2 selects the fast pair. Every other value (0, 1, 3) selects the standard pair.
- R4: After `enable` rises, the generator starts with a high phase. Every high phase, including that first one, lasts the selected high count + 3 clock cycles. The first phase is counted from the first edge that samples `enable` at 1.
- R5: Every low phase lasts the selected low count + 1 clock cycles. It is counted from the first cycle in which `scl_drive_low` is 1.
- R6: `scl_fall_stb` is 1 for exactly one cycle, and that cycle is the first cycle of each low phase.
- R7: `scl_rise_stb` is 1 for exactly one cycle, and that cycle is the first cycle of each high phase that follows a low phase.
- R8: A write through `cfg_we` loads `cfg_wdata` into the register chosen by `cfg_addr`: 0 is standard high, 1 is standard low, 2 is fast high, 3 is fast low. The write takes effect only when `enable` is 0; while `enable` is 1 the write is ignored.
- R9: `speed_sel` is sampled when each phase is loaded. A change during a phase affects the next phase, not the current one.
- R10: Dropping `enable` during a low phase releases SCL on the next edge and produces no rise strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; also locks the count registers |
| speed_sel | input | 2 | Speed select (2 = fast, other values = standard) |
| cfg_we | input | 1 | Count register write strobe |
| cfg_addr | input | 2 | Count register select |
| cfg_wdata | input | CNT_W | Count value to write |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| scl_fall_stb | output | 1 | One-cycle mark of the first low cycle |
| scl_rise_stb | output | 1 | One-cycle mark of the first high cycle after a low phase |

## Verification
The bench measures phase lengths in cycles. It checks zero counts, where an
overhead that is off by one, or a counter that wraps, shows up as a phase of 2 or
65538 cycles instead of 3 or 1. Speed codes 0 and 3 are driven to show they fall
back to the standard pair; a decoder that tested a single bit would pick the fast
counts instead. `speed_sel` is flipped partway through a high phase, so a design
that reads speed combinationally would shorten the phase already running. The
bench also writes a register while enabled, which a missing lock would let through
to the next period. Finally it drops `enable` while SCL is low, where a careless
design would emit a stray rise strobe or hold SCL low.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  localparam int unsigned HI_OVH = 3;
  localparam int unsigned LO_OVH = 1;
  localparam int unsigned NUM_CNT_REGS = 4;

  typedef enum logic [1:0] {
    CR_STD_HI  = 2'd0,
    CR_STD_LO  = 2'd1,
    CR_FAST_HI = 2'd2,
    CR_FAST_LO = 2'd3
  } cnt_reg_e;

  // R3: only code 2 selects the fast pair
  function automatic logic speed_is_fast(input logic [1:0] code);
    return code == 2'd2;
  endfunction
endpackage

// File: rtl/scl_cnt_regs.sv
module scl_cnt_regs
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter logic [NUM_CNT_REGS-1:0][CNT_W-1:0] RST_VALS = '0
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   enable_i,
  input  logic                                   we_i,
  input  logic [1:0]                             addr_i,
  input  logic [CNT_W-1:0]                       wdata_i,
  output logic [NUM_CNT_REGS-1:0][CNT_W-1:0]     regs_o
);
  logic [NUM_CNT_REGS-1:0][CNT_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_CNT_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= RST_VALS[g];
      end else if (we_i && !enable_i && (addr_i == 2'(g))) begin
        regs_q[g] <= wdata_i;
      end
    end
  end

  assign regs_o = regs_q;

  // R8: counts cannot move while the generator runs
  assert_locked_when_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |=> $stable(regs_q));
endmodule

// File: rtl/scl_phase_sel.sv
module scl_phase_sel
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PH_W = CNT_W + 2
) (
  input  logic [NUM_CNT_REGS-1:0][CNT_W-1:0] regs_i,
  input  logic [1:0]                         speed_i,
  output logic [PH_W-1:0]                    hi_len_m1_o,
  output logic [PH_W-1:0]                    lo_len_m1_o
);
  logic             fast;
  logic [CNT_W-1:0] hi_cnt;
  logic [CNT_W-1:0] lo_cnt;

  always_comb begin
    fast   = speed_is_fast(speed_i);
    hi_cnt = fast ? regs_i[CR_FAST_HI] : regs_i[CR_STD_HI];
    lo_cnt = fast ? regs_i[CR_FAST_LO] : regs_i[CR_STD_LO];
    hi_len_m1_o = PH_W'(hi_cnt) + PH_W'(HI_OVH - 1);
    lo_len_m1_o = PH_W'(lo_cnt) + PH_W'(LO_OVH - 1);
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int unsigned PH_W = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable_i,
  input  logic [PH_W-1:0] hi_len_m1_i,
  input  logic [PH_W-1:0] lo_len_m1_i,
  output logic            scl_low_o,
  output logic            fall_stb_o,
  output logic            rise_stb_o
);
  logic            active_q;
  logic            scl_low_q;
  logic            fall_q;
  logic            rise_q;
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      scl_low_q <= 1'b0;
      fall_q    <= 1'b0;
      rise_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (!enable_i) begin
      active_q  <= 1'b0;
      scl_low_q <= 1'b0;
      fall_q    <= 1'b0;
      rise_q    <= 1'b0;
      cnt_q     <= '0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      cnt_q    <= hi_len_m1_i;
      fall_q   <= 1'b0;
      rise_q   <= 1'b0;
    end else if (cnt_q == '0) begin
      scl_low_q <= !scl_low_q;
      cnt_q     <= scl_low_q ? hi_len_m1_i : lo_len_m1_i;
      fall_q    <= !scl_low_q;
      rise_q    <= scl_low_q;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
    end
  end

  assign scl_low_o  = scl_low_q;
  assign fall_stb_o = fall_q;
  assign rise_stb_o = rise_q;

  assert_release_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!scl_low_q && !fall_q && !rise_q));
  assert_hold_mid_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && active_q && cnt_q != '0) |=> $stable(scl_low_q));
  assert_fall_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> scl_low_q);
  assert_fall_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_q) |-> fall_q);
  assert_rise_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (!scl_low_q && $past(scl_low_q)));
  assert_strobes_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_q && rise_q));
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned STD_HI_RST  = 10,
  parameter int unsigned STD_LO_RST  = 12,
  parameter int unsigned FAST_HI_RST = 2,
  parameter int unsigned FAST_LO_RST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       speed_sel,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             scl_drive_low,
  output logic             scl_fall_stb,
  output logic             scl_rise_stb
);
  localparam int unsigned PH_W = CNT_W + 2;
  localparam logic [NUM_CNT_REGS-1:0][CNT_W-1:0] RST_VALS = {
    CNT_W'(FAST_LO_RST), CNT_W'(FAST_HI_RST), CNT_W'(STD_LO_RST), CNT_W'(STD_HI_RST)
  };

  logic [NUM_CNT_REGS-1:0][CNT_W-1:0] regs;
  logic [PH_W-1:0]                    hi_len_m1;
  logic [PH_W-1:0]                    lo_len_m1;

  scl_cnt_regs #(.CNT_W(CNT_W), .RST_VALS(RST_VALS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable_i (enable),
    .we_i     (cfg_we),
    .addr_i   (cfg_addr),
    .wdata_i  (cfg_wdata),
    .regs_o   (regs)
  );

  scl_phase_sel #(.CNT_W(CNT_W)) u_sel (
    .regs_i      (regs),
    .speed_i     (speed_sel),
    .hi_len_m1_o (hi_len_m1),
    .lo_len_m1_o (lo_len_m1)
  );

  scl_phase_timer #(.PH_W(PH_W)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable),
    .hi_len_m1_i (hi_len_m1),
    .lo_len_m1_i (lo_len_m1),
    .scl_low_o   (scl_drive_low),
    .fall_stb_o  (scl_fall_stb),
    .rise_stb_o  (scl_rise_stb)
  );

  // R1: outputs idle in the first cycle out of reset
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!scl_drive_low && !scl_fall_stb && !scl_rise_stb));
endmodule

// File: tb/scl_period_gen_tb_top.sv
module scl_period_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  speed_sel = 2'd1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = '0;
  logic        scl_drive_low, scl_fall_stb, scl_rise_stb;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scl_period_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .speed_sel(speed_sel),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .scl_drive_low(scl_drive_low), .scl_fall_stb(scl_fall_stb),
    .scl_rise_stb(scl_rise_stb)
  );

  // speed, std_hi, std_lo, fast_hi, fast_lo, exp_high, exp_low
  localparam int NVEC = 6;
  localparam int VEC [NVEC][7] = '{
    '{1, 0, 0, 9, 9, 3, 1},
    '{1, 5, 7, 0, 0, 8, 8},
    '{2, 9, 9, 2, 4, 5, 5},
    '{2, 3, 3, 0, 0, 3, 1},
    '{0, 6, 2, 1, 1, 9, 3},
    '{3, 1, 1, 7, 0, 4, 2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // enable must have been raised at the preceding negedge
  task automatic measure(output int hi, output int lo, output int hi2,
                         output bit fs, output bit rs);
    hi = 0; lo = 1; hi2 = 1; fs = 0; rs = 0;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (scl_drive_low) break;
      hi++;
    end
    fs = scl_fall_stb && !scl_rise_stb;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (!scl_drive_low) break;
      if (scl_fall_stb || scl_rise_stb) fs = 0;
      lo++;
    end
    rs = scl_rise_stb && !scl_fall_stb;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (scl_drive_low) break;
      if (scl_fall_stb || scl_rise_stb) rs = 0;
      hi2++;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, lo, hi2;
    bit fs, rs;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!scl_drive_low && !scl_fall_stb && !scl_rise_stb, "R1 reset idle",
          int'({scl_drive_low, scl_fall_stb, scl_rise_stb}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!scl_drive_low, "R1 idle after reset", int'(scl_drive_low), 0);
    // R1/R4/R5: default counts at standard speed (10+3, 12+1)
    speed_sel = 2'd1;
    enable = 1'b1;
    measure(hi, lo, hi2, fs, rs);
    check(hi == 13, "R1 R4 default high", hi, 13);
    check(lo == 13, "R1 R5 default low", lo, 13);
    @(negedge clk); enable = 1'b0;
    // R2: released while disabled
    repeat (4) begin
      @(negedge clk);
      check(!scl_drive_low && !scl_fall_stb && !scl_rise_stb, "R2 released",
            int'({scl_drive_low, scl_fall_stb, scl_rise_stb}), 0);
    end

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      wr(0, VEC[v][1]); wr(1, VEC[v][2]); wr(2, VEC[v][3]); wr(3, VEC[v][4]);
      @(negedge clk);
      speed_sel = 2'(VEC[v][0]);
      enable = 1'b1;
      measure(hi, lo, hi2, fs, rs);
      check(hi == VEC[v][5], $sformatf("R3 R4 vec%0d first high", v), hi, VEC[v][5]);
      check(lo == VEC[v][6], $sformatf("R5 R8 vec%0d low", v), lo, VEC[v][6]);
      check(hi2 == VEC[v][5], $sformatf("R4 vec%0d second high", v), hi2, VEC[v][5]);
      check(fs, $sformatf("R6 vec%0d fall strobe", v), int'(fs), 1);
      check(rs, $sformatf("R7 vec%0d rise strobe", v), int'(rs), 1);
      @(negedge clk); enable = 1'b0;
      @(negedge clk);
    end

    // R8: write while enabled is ignored (std high stays 4)
    wr(0, 4); wr(1, 6); wr(2, 1); wr(3, 2);
    @(negedge clk); speed_sel = 2'd1; enable = 1'b1;
    wr(0, 40);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    measure(hi, lo, hi2, fs, rs);
    check(hi == 7, "R8 write while enabled ignored", hi, 7);
    @(negedge clk); enable = 1'b0;

    // R9: speed change mid high phase (std high 4+3, then fast low 2+1, fast high 1+3)
    @(negedge clk); speed_sel = 2'd1; enable = 1'b1;
    hi = 0;
    for (int g = 0; g < 2; g++) begin
      @(negedge clk);
      if (!scl_drive_low) hi++;
    end
    speed_sel = 2'd2;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (scl_drive_low) break;
      hi++;
    end
    lo = 1;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (!scl_drive_low) break;
      lo++;
    end
    hi2 = 1;
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (scl_drive_low) break;
      hi2++;
    end
    check(hi == 7, "R9 current phase keeps old speed", hi, 7);
    check(lo == 3, "R9 next low uses new speed", lo, 3);
    check(hi2 == 4, "R9 next high uses new speed", hi2, 4);

    // R10: disable during low phase
    @(negedge clk);
    check(scl_drive_low, "R10 in low phase", int'(scl_drive_low), 1);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_drive_low, "R10 released next edge", int'(scl_drive_low), 0);
    check(!scl_rise_stb, "R10 no rise strobe", int'(scl_rise_stb), 0);
    @(negedge clk);
    check(!scl_rise_stb && !scl_fall_stb, "R10 strobes quiet",
          int'({scl_fall_stb, scl_rise_stb}), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule